// File: doc/BRIEF.md
# Dual-Personality Context Switch Detector

This block watches the write traffic of a host bus that feeds an audio device with two personalities. One is a newer codec that occupies a 4-byte address window; the other is an older compatible codec that occupies a 16-byte window. A single context bit records which of the two the software is driving. When software writes into the window of the personality that is not active, the bit toggles. If the switch interrupt is enabled and an interrupt line has been assigned, the block also sets a sticky flag and pulses an interrupt request.

Every snooped write also decides which personality owns the FM synthesizer. The block presents a status byte that holds the context, the switch flag and the pending interrupts of the three neighbouring sources. A read strobe on that byte clears the switch flag. The window bases, the enables and the source interrupts come from outside the block. The codecs themselves are not part of it.

Top module: `ctx_switch_snoop`

## Requirements
- R1: After reset the context is 0 (compatible personality), the switch flag is clear, `switch_irq_o` is low, and both FM ownership outputs are low.
- R2: With context 0, a write whose address ANDed with 0xFFFC equals `new_base_i` sets the context to 1. The change is visible on `status_o[7]` and `ctx_o` one clock after the write cycle.
- R3: With context 1, a write whose address ANDed with 0xFFF0 equals `compat_base_i` sets the context to 0 one clock after the write cycle.
- R4: A write into the window of the personality already active, or to any other address, leaves the context unchanged.
- R5: On a context flip with `sw_irq_en_i` and `irq_assigned_i` both high, `status_o[6]` is set and `switch_irq_o` pulses high for exactly one cycle, both one clock after the write. If either input is low, neither happens.
- R6: `status_o` is combinational and holds: bit 7 the context, bit 6 the switch flag, bit 5 `compat_irq_i`, bit 4 `new_irq_i`, bit 3 `mpu_irq_i`, and bits 2..0 always zero.
- R7: A cycle with `status_rd_i` high clears `status_o[6]` at the next clock and leaves bit 7 unchanged.
- R8: When a flip that sets the flag and a status read fall in the same cycle, the flag ends up set.
- R9: FM is enabled when `fm_if_en_i` is high and `mode_reg_i` AND 0x85 is zero. On every snooped write, one clock later, `fm_compat_o` equals (new context is 0 AND FM enabled) and `fm_new_o` equals (new context is 1 AND FM enabled). The new context is the one that results from that write.
- R10: Between snooped writes, both FM ownership outputs hold their values, even when `fm_if_en_i` or `mode_reg_i` change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_valid_i | input | 1 | A bus write is present this cycle |
| wr_addr_i | input | 16 | Address of the snooped write |
| status_rd_i | input | 1 | Status byte is read this cycle |
| new_base_i | input | 16 | Base of the newer-codec 4-byte window |
| compat_base_i | input | 16 | Base of the compatible 16-byte window |
| sw_irq_en_i | input | 1 | Switch interrupt enable (control bit) |
| irq_assigned_i | input | 1 | An interrupt line is assigned |
| fm_if_en_i | input | 1 | FM interface enable |
| mode_reg_i | input | 8 | Mode entry whose bits 7, 2, 0 block FM |
| mpu_irq_i | input | 1 | MPU interrupt pending |
| new_irq_i | input | 1 | Newer-codec interrupt pending |
| compat_irq_i | input | 1 | Compatible-codec interrupt pending |
| status_o | output | 8 | Status byte |
| ctx_o | output | 1 | Active context, 1 = newer codec |
| switch_irq_o | output | 1 | One-cycle switch interrupt request |
| fm_compat_o | output | 1 | Compatible personality owns FM |
| fm_new_o | output | 1 | Newer personality owns FM |

## Verification
The context, the switch flag, the interrupt pulse and both FM ownership bits are registered. Each of them is due exactly one clock after the cycle in which the write or read strobe is presented. The source-interrupt fields of the status byte follow their inputs within the same cycle. The bench drives every stimulus on a falling edge and holds it for one rising edge. It samples one time unit after that edge, so each registered result is read in the cycle it first becomes valid. Checks of holding behaviour are made after input changes and before the next write, so any leak would already show.

// File: rtl/ctx_pkg.sv
package ctx_pkg;
  typedef enum logic {
    CTX_COMPAT = 1'b0,
    CTX_NEW    = 1'b1
  } ctx_e;

  localparam int unsigned ST_CTX    = 7;
  localparam int unsigned ST_FLAG   = 6;
  localparam int unsigned ST_COMPAT = 5;
  localparam int unsigned ST_NEW    = 4;
  localparam int unsigned ST_MPU    = 3;
endpackage

// File: rtl/win_hit.sv
module win_hit #(
  parameter int unsigned ADDR_W  = 16,
  parameter int unsigned SPAN_LG = 2
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [ADDR_W-1:0] base_i,
  output logic              hit_o
);
  localparam logic [ADDR_W-1:0] MASK = ~((ADDR_W'(1) << SPAN_LG) - ADDR_W'(1));

  // full base compared: unaligned base never matches
  assign hit_o = ((addr_i & MASK) == base_i);
endmodule

// File: rtl/ctx_core.sv
module ctx_core
  import ctx_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic flip_i,
  input  logic irq_ok_i,
  input  logic rd_i,
  output ctx_e ctx_o,
  output logic flag_o,
  output logic irq_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctx_o  <= CTX_COMPAT;
      flag_o <= 1'b0;
      irq_o  <= 1'b0;
    end else begin
      if (flip_i) ctx_o <= (ctx_o == CTX_NEW) ? CTX_COMPAT : CTX_NEW;
      irq_o <= flip_i && irq_ok_i;
      // set wins over read-clear
      if (flip_i && irq_ok_i) flag_o <= 1'b1;
      else if (rd_i)          flag_o <= 1'b0;
    end
  end
endmodule

// File: rtl/fm_route.sv
module fm_route
  import ctx_pkg::*;
#(
  parameter logic [7:0] BLOCK_MASK = 8'h85
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wr_i,
  input  ctx_e       ctx_next_i,
  input  logic       fm_if_en_i,
  input  logic [7:0] mode_i,
  output logic       fm_compat_o,
  output logic       fm_new_o
);
  logic fm_ok;
  assign fm_ok = fm_if_en_i && ((mode_i & BLOCK_MASK) == 8'h00);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fm_compat_o <= 1'b0;
      fm_new_o    <= 1'b0;
    end else if (wr_i) begin
      fm_compat_o <= fm_ok && (ctx_next_i == CTX_COMPAT);
      fm_new_o    <= fm_ok && (ctx_next_i == CTX_NEW);
    end
  end
endmodule

// File: rtl/ctx_switch_snoop.sv
module ctx_switch_snoop
  import ctx_pkg::*;
#(
  parameter int unsigned ADDR_W     = 16,
  parameter int unsigned NEW_LG     = 2,
  parameter int unsigned COMPAT_LG  = 4,
  parameter logic [7:0]  FM_BLOCK   = 8'h85
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_valid_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic              status_rd_i,
  input  logic [ADDR_W-1:0] new_base_i,
  input  logic [ADDR_W-1:0] compat_base_i,
  input  logic              sw_irq_en_i,
  input  logic              irq_assigned_i,
  input  logic              fm_if_en_i,
  input  logic [7:0]        mode_reg_i,
  input  logic              mpu_irq_i,
  input  logic              new_irq_i,
  input  logic              compat_irq_i,
  output logic [7:0]        status_o,
  output logic              ctx_o,
  output logic              switch_irq_o,
  output logic              fm_compat_o,
  output logic              fm_new_o
);
  logic hit_new, hit_compat, flip, flag;
  ctx_e ctx_q, ctx_next;

  win_hit #(.ADDR_W(ADDR_W), .SPAN_LG(NEW_LG)) u_hit_new (
    .addr_i(wr_addr_i), .base_i(new_base_i), .hit_o(hit_new)
  );
  win_hit #(.ADDR_W(ADDR_W), .SPAN_LG(COMPAT_LG)) u_hit_compat (
    .addr_i(wr_addr_i), .base_i(compat_base_i), .hit_o(hit_compat)
  );

  // only the inactive personality's window toggles
  assign flip = wr_valid_i && ((ctx_q == CTX_NEW) ? hit_compat : hit_new);
  assign ctx_next = flip ? ((ctx_q == CTX_NEW) ? CTX_COMPAT : CTX_NEW) : ctx_q;

  ctx_core u_core (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .flip_i  (flip),
    .irq_ok_i(sw_irq_en_i && irq_assigned_i),
    .rd_i    (status_rd_i),
    .ctx_o   (ctx_q),
    .flag_o  (flag),
    .irq_o   (switch_irq_o)
  );

  fm_route #(.BLOCK_MASK(FM_BLOCK)) u_fm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_i       (wr_valid_i),
    .ctx_next_i (ctx_next),
    .fm_if_en_i (fm_if_en_i),
    .mode_i     (mode_reg_i),
    .fm_compat_o(fm_compat_o),
    .fm_new_o   (fm_new_o)
  );

  assign ctx_o = (ctx_q == CTX_NEW);

  always_comb begin
    status_o            = 8'h00;
    status_o[ST_CTX]    = ctx_o;
    status_o[ST_FLAG]   = flag;
    status_o[ST_COMPAT] = compat_irq_i;
    status_o[ST_NEW]    = new_irq_i;
    status_o[ST_MPU]    = mpu_irq_i;
  end
endmodule

// File: rtl/ctx_switch_snoop_chk.sv
module ctx_switch_snoop_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       wr_valid_i,
  input logic       status_rd_i,
  input logic       sw_irq_en_i,
  input logic       irq_assigned_i,
  input logic [7:0] status_o,
  input logic       ctx_o,
  input logic       switch_irq_o,
  input logic       fm_compat_o,
  input logic       fm_new_o
);
  AST_CTX_NEEDS_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_valid_i |=> $stable(ctx_o)); // R4

  AST_CTX_MIRROR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_o[7] == ctx_o); // R6

  AST_LOW_BITS_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_o[2:0] == 3'b000); // R6

  AST_IRQ_NEEDS_ENABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    switch_irq_o |-> ($past(sw_irq_en_i && irq_assigned_i) && status_o[6])); // R5

  AST_IRQ_ON_FLIP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    switch_irq_o |-> (ctx_o != $past(ctx_o))); // R5

  AST_READ_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_rd_i && !wr_valid_i) |=> !status_o[6]); // R7

  AST_FM_EXCLUSIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(fm_compat_o && fm_new_o)); // R9

  AST_FM_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_valid_i |=> ($stable(fm_compat_o) && $stable(fm_new_o))); // R10
endmodule

bind ctx_switch_snoop ctx_switch_snoop_chk u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .wr_valid_i    (wr_valid_i),
  .status_rd_i   (status_rd_i),
  .sw_irq_en_i   (sw_irq_en_i),
  .irq_assigned_i(irq_assigned_i),
  .status_o      (status_o),
  .ctx_o         (ctx_o),
  .switch_irq_o  (switch_irq_o),
  .fm_compat_o   (fm_compat_o),
  .fm_new_o      (fm_new_o)
);

// File: tb/ctx_switch_snoop_test.sv
module ctx_switch_snoop_test;
  localparam time CLK_PERIOD = 10;
  localparam logic [15:0] NEW_B = 16'h0534;
  localparam logic [15:0] CMP_B = 16'h0220;

  logic clk = 1'b0, rst_n = 1'b0;
  logic wr = 1'b0, rd = 1'b0, irq_en = 1'b0, irq_as = 1'b0, fm_en = 1'b0;
  logic mpu = 1'b0, nirq = 1'b0, cirq = 1'b0;
  logic [15:0] addr = 16'h0;
  logic [7:0] mode = 8'h00;
  logic [7:0] status;
  logic ctx, sirq, fmc, fmn;
  int n_chk = 0, n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ctx_switch_snoop uut (
    .clk_i(clk), .rst_ni(rst_n), .wr_valid_i(wr), .wr_addr_i(addr),
    .status_rd_i(rd), .new_base_i(NEW_B), .compat_base_i(CMP_B),
    .sw_irq_en_i(irq_en), .irq_assigned_i(irq_as), .fm_if_en_i(fm_en),
    .mode_reg_i(mode), .mpu_irq_i(mpu), .new_irq_i(nirq), .compat_irq_i(cirq),
    .status_o(status), .ctx_o(ctx), .switch_irq_o(sirq),
    .fm_compat_o(fmc), .fm_new_o(fmn)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // one cycle of stimulus; results sampled just after the edge
  task automatic cyc(input logic w, input logic [15:0] a, input logic r);
    @(negedge clk);
    wr = w; addr = a; rd = r;
    @(posedge clk);
    #1;
    wr = 1'b0; rd = 1'b0;
  endtask

  task automatic t_reset;
    check("R1 status", status, 8'h00);
    check("R1 irq", {7'b0, sirq}, 8'h00);
    check("R1 fm", {6'b0, fmc, fmn}, 8'h00);
  endtask

  task automatic t_active_window;
    cyc(1, 16'h022F, 0);
    check("R4 compat win in ctx0", {7'b0, ctx}, 8'h00);
    cyc(1, 16'h0538, 0);
    check("R4 outside new win", {7'b0, ctx}, 8'h00);
  endtask

  task automatic t_flip_no_irq;
    irq_en = 1'b0; irq_as = 1'b1;
    cyc(1, 16'h0537, 0);
    check("R2 ctx to new", status & 8'hC0, 8'h80);
    check("R5 no pulse when disabled", {7'b0, sirq}, 8'h00);
    cyc(1, 16'h0535, 0);
    check("R4 new win in ctx1", {7'b0, ctx}, 8'h01);
    cyc(1, 16'h022A, 0);
    check("R3 ctx to compat", status & 8'hC0, 8'h00);
  endtask

  task automatic t_flip_irq;
    irq_en = 1'b1; irq_as = 1'b1;
    cyc(1, 16'h0534, 0);
    check("R5 flag set", status & 8'hC0, 8'hC0);
    check("R5 pulse", {7'b0, sirq}, 8'h01);
    cyc(0, 16'h0, 0);
    check("R5 pulse one cycle", {7'b0, sirq}, 8'h00);
    check("R5 flag sticky", status & 8'hC0, 8'hC0);
    cyc(0, 16'h0, 1);
    check("R7 read clears flag only", status & 8'hC0, 8'h80);
  endtask

  task automatic t_unassigned;
    irq_en = 1'b1; irq_as = 1'b0;
    cyc(1, 16'h0220, 0);
    check("R5 no flag unassigned", status & 8'hC0, 8'h00);
    check("R5 no pulse unassigned", {7'b0, sirq}, 8'h00);
  endtask

  task automatic t_same_cycle;
    irq_en = 1'b1; irq_as = 1'b1;
    cyc(1, 16'h0536, 1);
    check("R8 flip wins over read", status & 8'hC0, 8'hC0);
    cyc(0, 16'h0, 1);
    check("R7 later read clears", status & 8'hC0, 8'h80);
  endtask

  task automatic t_sources;
    mpu = 1'b1; #1;
    check("R6 mpu bit3", status, 8'h88);
    nirq = 1'b1; cirq = 1'b1; #1;
    check("R6 all sources", status, 8'hB8);
    mpu = 1'b0; nirq = 1'b0; #1;
    check("R6 compat bit5", status, 8'hA0);
    cirq = 1'b0;
  endtask

  task automatic t_fm;
    fm_en = 1'b1; mode = 8'h00;
    cyc(1, 16'h0100, 0);
    check("R9 new owns fm", {6'b0, fmc, fmn}, 8'h01);
    mode = 8'h04; #1;
    check("R10 hold on mode change", {6'b0, fmc, fmn}, 8'h01);
    cyc(1, 16'h0100, 0);
    check("R9 bit2 blocks fm", {6'b0, fmc, fmn}, 8'h00);
    mode = 8'h40;
    cyc(1, 16'h0100, 0);
    check("R9 bit6 does not block", {6'b0, fmc, fmn}, 8'h01);
    cyc(1, 16'h0225, 0);
    check("R9 flip write moves fm", {6'b0, fmc, fmn}, 8'h02);
    fm_en = 1'b0;
    cyc(0, 16'h0, 0);
    check("R10 hold on enable drop", {6'b0, fmc, fmn}, 8'h02);
    cyc(1, 16'h0300, 0);
    check("R9 disabled clears", {6'b0, fmc, fmn}, 8'h00);
  endtask

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    t_reset;
    @(negedge clk); rst_n = 1'b1;
    t_reset;
    t_active_window;
    t_flip_no_irq;
    t_flip_irq;
    t_unassigned;
    t_same_cycle;
    t_sources;
    t_fm;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule